// File: doc/BRIEF.md
# Laser output enable sequencer

This block decides when a burst-mode laser controller may drive its modulation and bias outputs. After power-up it holds both off until the supply flag is good, a temperature conversion has completed and, if the supply-low alarm is armed, the latest supply conversion is above the programmed low level. Once running, any of three disable sources switches the outputs off at once. They are the hardware disable pin, the software disable bit and a latched fault flag.

A re-enable after a disable does not wait for new conversions. Modulation comes back using the index of the last stored temperature, and a fresh bias search is requested. The block also turns each recorded temperature into a modulation table index. It produces a one-cycle search start pulse while burst enable is high, and it routes bias to a manual source when automatic bias is off.

Top module: `laser_en_seq`

## Requirements
- R1: After reset, `mod_en` stays 0 until an edge at which `supply_ok` is 1, a `temp_done` pulse was sampled at an earlier edge, and no disable is active. `mod_en` is 1 after that edge.
- R2: When `vlo_alarm_en` is 1, enabling also needs the most recent `vcc_done` sample to have `vcc_val` strictly greater than `vlo_thresh`. A result equal to the threshold does not qualify.
- R3: `mod_idx` = (T + 40) / 2, rounded down, for a stored temperature T in signed whole degrees. It is 0 for T below -40 and 71 for any index above 71, so the table has 72 entries covering -40 to +102.
- R4: If a disable source is sampled high, `mod_en` is 0 after that edge and stays 0 while the disable is held. Any bias search not yet started is dropped.
- R5: The effective disable is the OR of `txd_pin`, `txd_soft` and `fault_latched`, and each one alone has the same effect.
- R6: When all disables are released after operation, `mod_en` returns to 1 after the next edge without a new conversion. `mod_idx` keeps its stored value, and a new bias search is requested.
- R7: `mod_idx` is loaded one edge after `temp_done` is sampled and does not change otherwise.
- R8: While `bias_auto_en` is 0, `bias_manual` is 1 and `bias_start` never pulses.
- R9: `bias_start` is a single-cycle pulse, issued once per enable. It comes one edge after an edge where `mod_en` is 1 and `burst_en` is sampled high.
- R10: When `supply_ok` drops, the outputs go off and the power-up wait of R1 and R2 applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above power-on threshold |
| temp_done | input | 1 | Temperature conversion finished (pulse) |
| temp_val | input | TEMP_W | Converted temperature, signed degrees |
| vcc_done | input | 1 | Supply conversion finished (pulse) |
| vcc_val | input | VCC_W | Supply conversion result |
| vlo_alarm_en | input | 1 | Supply-low check required for enable |
| vlo_thresh | input | VCC_W | Supply-low level |
| txd_pin | input | 1 | Hardware transmit disable |
| txd_soft | input | 1 | Software transmit disable |
| fault_latched | input | 1 | Latched fault, disables outputs |
| bias_auto_en | input | 1 | 1: bias by search, 0: manual bias |
| burst_en | input | 1 | Burst enable |
| mod_en | output | 1 | Modulation output enable |
| mod_idx | output | IDX_W | Modulation table index |
| bias_start | output | 1 | Bias search start pulse |
| bias_manual | output | 1 | Bias taken from manual register |

## Verification
Every result is registered. `mod_idx` changes one edge after a `temp_done` sample, and `mod_en` follows its enable or disable condition by one edge. That makes `mod_en` rise two edges after the first temperature pulse or a qualifying supply result, and `bias_start` one edge after `mod_en` rises with burst enable high. The bench changes inputs just after a falling edge and reads outputs at the next falling edge, so each check sees exactly one rising edge between stimulus and response. Multi-edge results are stepped and checked edge by edge, including the edges where the output must still be low.

// File: rtl/laser_en_pkg.sv
package laser_en_pkg;

    typedef enum logic [1:0] {
        ST_COLD = 2'd0,
        ST_ON   = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_e;

endpackage

// File: rtl/lseq_temp_index.sv
module lseq_temp_index #(
    parameter int TEMP_W    = 8,
    parameter int TEMP_MIN  = -40,
    parameter int TEMP_STEP = 2,
    parameter int TABLE_N   = 72,
    parameter int IDX_W     = 7
) (
    input  logic signed [TEMP_W-1:0] temp_i,
    output logic        [IDX_W-1:0]  idx_o
);

    int off;
    int q;

    always_comb begin
        off = int'(temp_i) - TEMP_MIN;
        if (off < 0) begin
            q = 0;
        end else begin
            q = off / TEMP_STEP;
            if (q > TABLE_N - 1) begin
                q = TABLE_N - 1;
            end
        end
        idx_o = IDX_W'(q);
    end

endmodule

// File: rtl/lseq_power_gate.sv
module lseq_power_gate #(
    parameter int VCC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok_i,
    input  logic             temp_done_i,
    input  logic             vcc_done_i,
    input  logic [VCC_W-1:0] vcc_val_i,
    input  logic [VCC_W-1:0] vlo_thresh_i,
    input  logic             vlo_en_i,
    output logic             ready_o
);

    typedef struct packed {
        logic temp_seen;
        logic vcc_good;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (temp_done_i) begin
            g_d.temp_seen = 1'b1;
        end
        if (vcc_done_i) begin
            g_d.vcc_good = (vcc_val_i > vlo_thresh_i);
        end
        if (!supply_ok_i) begin
            g_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign ready_o = supply_ok_i && g_q.temp_seen && (!vlo_en_i || g_q.vcc_good);

endmodule

// File: rtl/laser_en_seq.sv
module laser_en_seq
    import laser_en_pkg::*;
#(
    parameter int TEMP_W    = 8,
    parameter int VCC_W     = 10,
    parameter int TEMP_MIN  = -40,
    parameter int TEMP_STEP = 2,
    parameter int TABLE_N   = 72,
    localparam int IDX_W    = $clog2(TABLE_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     supply_ok,
    input  logic                     temp_done,
    input  logic signed [TEMP_W-1:0] temp_val,
    input  logic                     vcc_done,
    input  logic [VCC_W-1:0]         vcc_val,
    input  logic                     vlo_alarm_en,
    input  logic [VCC_W-1:0]         vlo_thresh,
    input  logic                     txd_pin,
    input  logic                     txd_soft,
    input  logic                     fault_latched,
    input  logic                     bias_auto_en,
    input  logic                     burst_en,
    output logic                     mod_en,
    output logic [IDX_W-1:0]         mod_idx,
    output logic                     bias_start,
    output logic                     bias_manual
);

    logic             dis;
    logic             ready;
    logic [IDX_W-1:0] idx_new;

    assign dis = txd_pin | txd_soft | fault_latched;

    lseq_power_gate #(
        .VCC_W(VCC_W)
    ) gate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok),
        .temp_done_i (temp_done),
        .vcc_done_i  (vcc_done),
        .vcc_val_i   (vcc_val),
        .vlo_thresh_i(vlo_thresh),
        .vlo_en_i    (vlo_alarm_en),
        .ready_o     (ready)
    );

    lseq_temp_index #(
        .TEMP_W   (TEMP_W),
        .TEMP_MIN (TEMP_MIN),
        .TEMP_STEP(TEMP_STEP),
        .TABLE_N  (TABLE_N),
        .IDX_W    (IDX_W)
    ) index_i (
        .temp_i(temp_val),
        .idx_o (idx_new)
    );

    typedef struct packed {
        seq_state_e       st;
        logic             pend;
        logic             start;
        logic             manual;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.start  = 1'b0;
        s_d.manual = !bias_auto_en;
        if (temp_done) begin
            s_d.idx = idx_new;
        end
        case (s_q.st)
            ST_COLD: begin
                if (ready && !dis) begin
                    s_d.st   = ST_ON;
                    s_d.pend = bias_auto_en;
                end
            end
            ST_ON: begin
                if (dis) begin
                    s_d.st   = ST_HOLD;
                    s_d.pend = 1'b0;
                end else if (!bias_auto_en) begin
                    s_d.pend = 1'b0;
                end else if (s_q.pend && burst_en) begin
                    s_d.start = 1'b1;
                    s_d.pend  = 1'b0;
                end
            end
            ST_HOLD: begin
                if (!dis) begin
                    s_d.st   = ST_ON;
                    s_d.pend = bias_auto_en;
                end
            end
            default: begin
                s_d.st   = ST_COLD;
                s_d.pend = 1'b0;
            end
        endcase
        if (!supply_ok) begin
            s_d.st    = ST_COLD;
            s_d.pend  = 1'b0;
            s_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mod_en      = (s_q.st == ST_ON);
    assign mod_idx     = s_q.idx;
    assign bias_start  = s_q.start;
    assign bias_manual = s_q.manual;

endmodule

// File: rtl/laser_en_seq_chk.sv
module laser_en_seq_chk #(
    parameter int TABLE_N = 72,
    parameter int IDX_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             supply_ok,
    input logic             temp_done,
    input logic             txd_pin,
    input logic             txd_soft,
    input logic             fault_latched,
    input logic             bias_auto_en,
    input logic             burst_en,
    input logic             mod_en,
    input logic [IDX_W-1:0] mod_idx,
    input logic             bias_start,
    input logic             bias_manual
);

    AST_OFF_NO_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !mod_en); // R10

    AST_IDX_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mod_idx <= IDX_W'(TABLE_N - 1)); // R3

    AST_OFF_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_pin || txd_soft || fault_latched) |=> !mod_en); // R5

    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_done |=> $stable(mod_idx)); // R7

    AST_MANUAL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        !bias_auto_en |=> (bias_manual && !bias_start)); // R8

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bias_start |=> !bias_start); // R9

    AST_START_WITH_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        bias_start |-> (mod_en && $past(burst_en) && $past(mod_en))); // R9

endmodule

bind laser_en_seq laser_en_seq_chk #(
    .TABLE_N(TABLE_N),
    .IDX_W  (IDX_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .temp_done    (temp_done),
    .txd_pin      (txd_pin),
    .txd_soft     (txd_soft),
    .fault_latched(fault_latched),
    .bias_auto_en (bias_auto_en),
    .burst_en     (burst_en),
    .mod_en       (mod_en),
    .mod_idx      (mod_idx),
    .bias_start   (bias_start),
    .bias_manual  (bias_manual)
);

// File: tb/laser_en_seq_tb_top.sv
`timescale 1ns/1ps
module laser_en_seq_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              supply_ok = 1'b0;
    logic              temp_done = 1'b0;
    logic signed [7:0] temp_val = '0;
    logic              vcc_done = 1'b0;
    logic [9:0]        vcc_val = '0;
    logic              vlo_alarm_en = 1'b0;
    logic [9:0]        vlo_thresh = '0;
    logic              txd_pin = 1'b0;
    logic              txd_soft = 1'b0;
    logic              fault_latched = 1'b0;
    logic              bias_auto_en = 1'b1;
    logic              burst_en = 1'b1;
    logic              mod_en;
    logic [6:0]        mod_idx;
    logic              bias_start;
    logic              bias_manual;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    laser_en_seq dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .temp_done(temp_done),
        .temp_val(temp_val), .vcc_done(vcc_done), .vcc_val(vcc_val),
        .vlo_alarm_en(vlo_alarm_en), .vlo_thresh(vlo_thresh), .txd_pin(txd_pin),
        .txd_soft(txd_soft), .fault_latched(fault_latched), .bias_auto_en(bias_auto_en),
        .burst_en(burst_en), .mod_en(mod_en), .mod_idx(mod_idx),
        .bias_start(bias_start), .bias_manual(bias_manual)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_idx(input int t);
        int q;
        if (t < -40) return 0;
        q = (t + 40) / 2;
        return (q > 71) ? 71 : q;
    endfunction

    task automatic pulse_temp(input int t);
        temp_val  = 8'(t);
        temp_done = 1'b1;
        tick();
        temp_done = 1'b0;
    endtask

    // releases a disable source and checks the re-enable path: R6, R9
    task automatic reenable_check(input string req);
        tick();
        chk({req, " mod_en off while disabled"}, int'(mod_en), 0);
        txd_pin = 1'b0; txd_soft = 1'b0; fault_latched = 1'b0;
        tick();
        chk("R6 mod_en back after release", int'(mod_en), 1);
        chk("R6 index kept", int'(mod_idx), exp_idx(25));
        tick();
        chk("R9 new search start", int'(bias_start), 1);
        tick();
        chk("R9 start single cycle", int'(bias_start), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset mod_en", int'(mod_en), 0);
        chk("R9 reset bias_start", int'(bias_start), 0);
        chk("R7 reset index", int'(mod_idx), 0);

        // R1: supply alone is not enough
        supply_ok = 1'b1;
        repeat (4) begin
            tick();
            chk("R1 no conversion yet", int'(mod_en), 0);
        end
        pulse_temp(25);
        chk("R7 index after conversion", int'(mod_idx), exp_idx(25));
        chk("R1 still off one edge after conversion", int'(mod_en), 0);
        tick();
        chk("R1 enabled", int'(mod_en), 1);
        tick();
        chk("R9 start after enable", int'(bias_start), 1);
        tick();
        chk("R9 start single cycle", int'(bias_start), 0);

        // R4/R5: each disable source
        txd_pin = 1'b1;
        tick();
        chk("R4 pin disables", int'(mod_en), 0);
        reenable_check("R4");
        txd_soft = 1'b1;
        tick();
        chk("R5 soft bit disables", int'(mod_en), 0);
        reenable_check("R5");
        fault_latched = 1'b1;
        tick();
        chk("R5 fault disables", int'(mod_en), 0);
        reenable_check("R5");

        // R9 burst gating, R4 dropping a pending search
        burst_en = 1'b0;
        txd_pin = 1'b1; tick();
        txd_pin = 1'b0; tick();
        chk("R6 mod_en back", int'(mod_en), 1);
        repeat (3) begin
            tick();
            chk("R9 no start without burst", int'(bias_start), 0);
        end
        txd_pin = 1'b1; tick();
        chk("R4 off", int'(mod_en), 0);
        burst_en = 1'b1;
        repeat (3) begin
            tick();
            chk("R4 pending search dropped", int'(bias_start), 0);
        end
        txd_pin = 1'b0; tick();
        chk("R6 mod_en back", int'(mod_en), 1);
        tick();
        chk("R9 start with burst", int'(bias_start), 1);
        tick();

        // R8 manual bias
        bias_auto_en = 1'b0;
        tick();
        chk("R8 manual select", int'(bias_manual), 1);
        txd_soft = 1'b1; tick();
        txd_soft = 1'b0; tick();
        chk("R8 mod_en back", int'(mod_en), 1);
        repeat (4) begin
            tick();
            chk("R8 no start in manual", int'(bias_start), 0);
        end
        bias_auto_en = 1'b1;
        tick();
        chk("R8 auto select", int'(bias_manual), 0);

        // R10 supply loss, R2 supply-low check
        supply_ok = 1'b0;
        tick();
        chk("R10 off on supply loss", int'(mod_en), 0);
        supply_ok = 1'b1;
        vlo_alarm_en = 1'b1;
        vlo_thresh = 10'd100;
        repeat (3) begin
            tick();
            chk("R10 waits for conversion again", int'(mod_en), 0);
        end
        pulse_temp(-50);
        chk("R3 clamp low", int'(mod_idx), 0);
        repeat (3) begin
            tick();
            chk("R2 waits for supply result", int'(mod_en), 0);
        end
        vcc_val = 10'd100; vcc_done = 1'b1; tick(); vcc_done = 1'b0;
        repeat (3) begin
            tick();
            chk("R2 equal level not enough", int'(mod_en), 0);
        end
        vcc_val = 10'd101; vcc_done = 1'b1; tick(); vcc_done = 1'b0;
        chk("R2 one edge after good result", int'(mod_en), 0);
        tick();
        chk("R2 enabled", int'(mod_en), 1);

        // R3/R7 full temperature sweep
        for (int t = -128; t < 128; t++) begin
            pulse_temp(t);
            chk("R3 index", int'(mod_idx), exp_idx(t));
            temp_val = 8'(-t - 1);
            tick();
            chk("R7 index held", int'(mod_idx), exp_idx(t));
        end
        chk("R3 sweep left mod_en on", int'(mod_en), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule